// File: doc/BRIEF.md
# Banked Internal Data Space

This block holds the on-chip data space of a small 8-bit accumulator core. A single access port resolves an 8-bit operand, under one of five access modes, to either a byte of general RAM or one of a handful of special-function registers (SFRs). The RAM is 128 bytes at 00h–7Fh. The SFR window lies at 80h and above and is separate from that RAM.

The lowest 32 bytes of RAM double as four banks of eight working registers. The active bank comes from two select bits of the flag word. The block also offers pointer access through the first two working registers of the active bank, and a byte stack driven by a stack-pointer SFR.

The core drives a mode, an operand, write data and a write enable each cycle. Read data comes back combinationally in the same cycle. All state changes take effect at the next rising clock edge. The flag word is always visible on its own output.

Top module: `idata_space`

## Requirements
- R1: In direct mode (acc_mode=1), operand 00h–7Fh addresses RAM; a write with wr_en=1 at the edge is returned by a later direct read of the same address.
- R2: In register mode (acc_mode=2), operand bits [2:0] pick working register n, stored at RAM address {RS1,RS0,n}, i.e. byte 8*bank+n; it is visible at that address in direct mode.
- R3: psw_out bits are CY=7, AC=6, F0=5, RS1=4, RS0=3, OV=2, user=1, P=0. Bits 7:1 are written through SFR D0h and bits 4:3 select the register bank. P is read-only and equals the XOR of the ACC bits, one cycle after ACC is written.
- R4: Direct operands with bit 7 set go to the SFR window. SP is at 81h, PSW at D0h, ACC at E0h and B at F0h. Any other SFR address reads 00h, ignores writes, and leaves RAM untouched.
- R5: In indirect mode (acc_mode=3), operand bit 0 picks R0 or R1 of the active bank as the pointer. The access goes to RAM at the pointer value. A pointer of 80h or above reads 00h and drops the write.
- R6: SP resets to 07h. Push (acc_mode=4) increments SP and then stores wr_data at the new SP, so the first push lands at 08h.
- R7: Pop (acc_mode=5) returns the byte at the current SP on rd_data in that cycle, then decrements SP at the edge.
- R8: After reset SP=07h and PSW, ACC and B read 00h.
- R9: Modes 0 (idle), 6 and 7 perform no access and drive rd_data=00h; push also drives rd_data=00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_mode | input | 3 | Access mode: 0 idle, 1 direct, 2 register, 3 indirect, 4 push, 5 pop |
| op_addr | input | 8 | Direct address, register number [2:0], or pointer select [0] |
| wr_en | input | 1 | Write request for direct, register and indirect modes |
| wr_data | input | 8 | Write or push data |
| rd_data | output | 8 | Combinational read data of the current access |
| psw_out | output | 8 | Flag word with live parity bit |

## Verification
The embedded assertions check on every cycle that the stack pointer moves by exactly one on push and pop and starts at 07h after reset. They also check that SFR-window and out-of-range pointer accesses never raise the RAM write strobe, and that idle modes return zero. The mapping of register operands into the right bank, the parity tracking over all 256 accumulator values, and the exact bytes written and read by indirect and stack operations can only be shown by the bench sweeps. Those sweeps compare every read against a shadow copy of the address space.

// File: rtl/idata_pkg.sv
package idata_pkg;
  typedef enum logic [2:0] {
    MD_NONE = 3'd0,
    MD_DIR  = 3'd1,
    MD_REG  = 3'd2,
    MD_IND  = 3'd3,
    MD_PUSH = 3'd4,
    MD_POP  = 3'd5
  } mode_e;

  localparam int unsigned DW        = 8;
  localparam int unsigned BANK_W    = 2;
  localparam int unsigned REG_SEL_W = 3;

  localparam logic [DW-1:0] SFR_SP  = 8'h81;
  localparam logic [DW-1:0] SFR_PSW = 8'hD0;
  localparam logic [DW-1:0] SFR_ACC = 8'hE0;
  localparam logic [DW-1:0] SFR_B   = 8'hF0;
endpackage

// File: rtl/idata_addr_map.sv
module idata_addr_map
  import idata_pkg::*;
#(
  parameter int unsigned RAM_BYTES = 128
) (
  input  mode_e               mode,
  input  logic [DW-1:0]       op_addr,
  input  logic [BANK_W-1:0]   bank,
  input  logic [DW-1:0]       ptr0,
  input  logic [DW-1:0]       ptr1,
  input  logic [DW-1:0]       sp,
  output logic [DW-1:0]       tgt,
  output logic                tgt_ram,
  output logic                tgt_sfr
);
  localparam logic [DW:0] RAM_LIMIT = (DW+1)'(RAM_BYTES);
  localparam int unsigned PAD_W = DW - BANK_W - REG_SEL_W;

  logic in_ram;
  assign in_ram = {1'b0, tgt} < RAM_LIMIT;

  always_comb begin
    tgt     = '0;
    tgt_ram = 1'b0;
    tgt_sfr = 1'b0;
    case (mode)
      MD_DIR: begin
        tgt     = op_addr;
        tgt_ram = in_ram && !op_addr[DW-1];
        tgt_sfr = op_addr[DW-1];
      end
      MD_REG: begin
        tgt     = {{PAD_W{1'b0}}, bank, op_addr[REG_SEL_W-1:0]};
        tgt_ram = in_ram;
      end
      MD_IND: begin
        tgt     = op_addr[0] ? ptr1 : ptr0;
        tgt_ram = in_ram;
      end
      MD_PUSH: begin
        tgt     = sp + 8'd1;
        tgt_ram = in_ram;
      end
      MD_POP: begin
        tgt     = sp;
        tgt_ram = in_ram;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/idata_ram.sv
module idata_ram
  import idata_pkg::*;
#(
  parameter int unsigned DEPTH = 128
) (
  input  logic          clk,
  input  logic          we,
  input  logic [DW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] p0addr,
  output logic [DW-1:0] p0data,
  input  logic [DW-1:0] p1addr,
  output logic [DW-1:0] p1data
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [DW:0] LIMIT = (DW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];

  logic wr_ok;
  assign wr_ok = we && ({1'b0, waddr} < LIMIT);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[waddr[AW-1:0]] <= wdata;
  end

  assign rdata  = ({1'b0, raddr}  < LIMIT) ? mem[raddr[AW-1:0]]  : '0;
  assign p0data = ({1'b0, p0addr} < LIMIT) ? mem[p0addr[AW-1:0]] : '0;
  assign p1data = ({1'b0, p1addr} < LIMIT) ? mem[p1addr[AW-1:0]] : '0;
endmodule

// File: rtl/idata_sfr.sv
module idata_sfr
  import idata_pkg::*;
#(
  parameter logic [7:0] SP_RESET = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DW-1:0]     waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     raddr,
  output logic [DW-1:0]     rdata,
  input  logic              push,
  input  logic              pop,
  output logic [DW-1:0]     sp,
  output logic [DW-1:0]     psw,
  output logic [BANK_W-1:0] bank
);
  logic [DW-1:0] sp_q, sp_d, acc_q, acc_d, b_q, b_d;
  logic [DW-1:1] psw_q, psw_d;
  logic          sp_en, acc_en, b_en, psw_en;

  always_comb begin
    sp_en  = push || pop || (we && waddr == SFR_SP);
    acc_en = we && waddr == SFR_ACC;
    b_en   = we && waddr == SFR_B;
    psw_en = we && waddr == SFR_PSW;
    if (push)     sp_d = sp_q + 8'd1;
    else if (pop) sp_d = sp_q - 8'd1;
    else          sp_d = wdata;
    acc_d = wdata;
    b_d   = wdata;
    psw_d = wdata[DW-1:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= SP_RESET;
      acc_q <= '0;
      b_q   <= '0;
      psw_q <= '0;
    end else begin
      if (sp_en)  sp_q  <= sp_d;
      if (acc_en) acc_q <= acc_d;
      if (b_en)   b_q   <= b_d;
      if (psw_en) psw_q <= psw_d;
    end
  end

  assign sp   = sp_q;
  assign psw  = {psw_q, ^acc_q};
  assign bank = psw_q[4:3];

  always_comb begin
    case (raddr)
      SFR_SP:  rdata = sp_q;
      SFR_PSW: rdata = psw;
      SFR_ACC: rdata = acc_q;
      SFR_B:   rdata = b_q;
      default: rdata = '0;
    endcase
  end

  // R6: push moves the pointer up by one
  a_r6_push_incr: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> sp_q == $past(sp_q) + 8'd1);
  // R7: pop moves the pointer down by one
  a_r7_pop_decr: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> sp_q == $past(sp_q) - 8'd1);
  // R8: pointer starts from its reset value
  a_r8_sp_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> sp_q == SP_RESET);
endmodule

// File: rtl/idata_space.sv
module idata_space
  import idata_pkg::*;
#(
  parameter int unsigned RAM_BYTES = 128,
  parameter logic [7:0]  SP_RESET  = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] acc_mode,
  input  logic [7:0] op_addr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic [7:0] psw_out
);
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  mode_e             md;
  logic [DW-1:0]     tgt, sp, ram_rd, sfr_rd, ptr0, ptr1;
  logic [BANK_W-1:0] bank;
  logic              tgt_ram, tgt_sfr, ram_we, sfr_we, rd_en, data_op;
  logic [DW-1:0]     p0addr, p1addr;

  assign md = mode_e'(acc_mode);
  assign p0addr = {3'b000, bank, 3'b000};
  assign p1addr = {3'b000, bank, 3'b001};

  idata_addr_map #(.RAM_BYTES(RAM_BYTES)) u_map (
    .mode(md), .op_addr(op_addr), .bank(bank), .ptr0(ptr0), .ptr1(ptr1),
    .sp(sp), .tgt(tgt), .tgt_ram(tgt_ram), .tgt_sfr(tgt_sfr)
  );

  always_comb begin
    data_op = (md == MD_DIR) || (md == MD_REG) || (md == MD_IND);
    rd_en   = data_op || (md == MD_POP);
    ram_we  = tgt_ram && ((wr_en && data_op) || (md == MD_PUSH));
    sfr_we  = tgt_sfr && wr_en && (md == MD_DIR);
    if (!rd_en)       rd_data = '0;
    else if (tgt_ram) rd_data = ram_rd;
    else if (tgt_sfr) rd_data = sfr_rd;
    else              rd_data = '0;
  end

  idata_ram #(.DEPTH(RAM_BYTES)) u_ram (
    .clk(clk), .we(ram_we), .waddr(tgt), .wdata(wr_data),
    .raddr(tgt), .rdata(ram_rd),
    .p0addr(p0addr), .p0data(ptr0), .p1addr(p1addr), .p1data(ptr1)
  );

  idata_sfr #(.SP_RESET(SP_RESET)) u_sfr (
    .clk(clk), .rst_n(rst_q), .we(sfr_we), .waddr(tgt), .wdata(wr_data),
    .raddr(tgt), .rdata(sfr_rd), .push(md == MD_PUSH), .pop(md == MD_POP),
    .sp(sp), .psw(psw_out), .bank(bank)
  );

  // R4: SFR-window accesses never write RAM
  a_r4_sfr_no_ram: assert property (@(posedge clk) disable iff (!rst_q)
    (md == MD_DIR && op_addr[7]) |-> !ram_we);
  // R5: pointer at or above 80h never writes RAM
  a_r5_hiptr_no_write: assert property (@(posedge clk) disable iff (!rst_q)
    (md == MD_IND && (op_addr[0] ? ptr1[7] : ptr0[7])) |-> !ram_we);
  // R9: no-access modes return zero and write nothing
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_q)
    (acc_mode == 3'd0 || acc_mode > 3'd5) |-> (rd_data == 8'h00 && !ram_we));
  // R1: RAM write strobe only for a requested write or a push
  a_r1_we_qual: assert property (@(posedge clk) disable iff (!rst_q)
    ram_we |-> (wr_en || md == MD_PUSH));
endmodule

// File: tb/tb_idata_space.sv
module tb_idata_space;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] acc_mode;
  logic [7:0] op_addr, wr_data, rd_data, psw_out;
  logic       wr_en;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] shadow [128];

  always #4 clk = ~clk;

  idata_space dut (
    .clk(clk), .rst_n(rst_n), .acc_mode(acc_mode), .op_addr(op_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .psw_out(psw_out)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic op(input logic [2:0] m, input logic [7:0] a, input logic w,
                    input logic [7:0] d, output logic [7:0] rd);
    @(negedge clk);
    acc_mode = m; op_addr = a; wr_en = w; wr_data = d;
    #1 rd = rd_data;
    @(posedge clk);
    #1 acc_mode = 3'd0; wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, v;
    acc_mode = 3'd0; op_addr = 8'h00; wr_en = 1'b0; wr_data = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R8 reset values
    op(3'd1, 8'h81, 1'b0, 8'h00, r); chk("R8 SP", r, 8'h07);
    op(3'd1, 8'hD0, 1'b0, 8'h00, r); chk("R8 PSW", r, 8'h00);
    op(3'd1, 8'hE0, 1'b0, 8'h00, r); chk("R8 ACC", r, 8'h00);
    op(3'd1, 8'hF0, 1'b0, 8'h00, r); chk("R8 B", r, 8'h00);
    chk("R8 psw_out", psw_out, 8'h00);

    // R1 direct sweep
    for (int a = 0; a < 128; a++) begin
      v = 8'((a * 37 + 5) & 255);
      shadow[a] = v;
      op(3'd1, 8'(a), 1'b1, v, r);
    end
    for (int a = 0; a < 128; a++) begin
      op(3'd1, 8'(a), 1'b0, 8'h00, r); chk("R1 direct", r, shadow[a]);
    end

    // R2/R3 banked registers
    for (int b = 0; b < 4; b++) begin
      op(3'd1, 8'hD0, 1'b1, 8'(b << 3), r);
      chk("R3 bank bits", psw_out, 8'(b << 3));
      for (int n = 0; n < 8; n++) begin
        v = 8'(b * 8 + n) ^ 8'hA5;
        shadow[b*8+n] = v;
        op(3'd2, 8'(n), 1'b1, v, r);
      end
      for (int n = 0; n < 8; n++) begin
        op(3'd2, 8'(n), 1'b0, 8'h00, r); chk("R2 reg read", r, shadow[b*8+n]);
      end
    end
    for (int a = 0; a < 32; a++) begin
      op(3'd1, 8'(a), 1'b0, 8'h00, r); chk("R2 bank via direct", r, shadow[a]);
    end

    // R3 parity sweep over all ACC values
    op(3'd1, 8'hD0, 1'b1, 8'h00, r);
    for (int x = 0; x < 256; x++) begin
      op(3'd1, 8'hE0, 1'b1, 8'(x), r);
      chk("R3 parity", {7'd0, psw_out[0]}, {7'd0, ^8'(x)});
    end
    op(3'd1, 8'hE0, 1'b1, 8'h00, r);
    op(3'd1, 8'hD0, 1'b1, 8'hFF, r);
    chk("R3 P read-only", psw_out, 8'hFE);
    op(3'd1, 8'hD0, 1'b0, 8'h00, r); chk("R3 PSW read", r, 8'hFE);

    // R4 SFR decode
    op(3'd1, 8'hF0, 1'b1, 8'h5A, r);
    op(3'd1, 8'hF0, 1'b0, 8'h00, r); chk("R4 B reg", r, 8'h5A);
    op(3'd1, 8'hE0, 1'b1, 8'h3C, r);
    op(3'd1, 8'hE0, 1'b0, 8'h00, r); chk("R4 ACC reg", r, 8'h3C);
    op(3'd1, 8'h85, 1'b1, 8'h77, r);
    op(3'd1, 8'h85, 1'b0, 8'h00, r); chk("R4 unmapped", r, 8'h00);
    op(3'd1, 8'h05, 1'b0, 8'h00, r); chk("R4 RAM untouched", r, shadow[5]);
    op(3'd1, 8'hE0, 1'b1, 8'h00, r);

    // R5 indirect via bank 1 pointers
    op(3'd1, 8'hD0, 1'b1, 8'h08, r);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] p;
      p = 8'(8'h30 + k * 3);
      op(3'd2, 8'd0, 1'b1, p, r); shadow[8] = p;
      v = 8'(k * 11 + 1);
      op(3'd3, 8'h00, 1'b1, v, r); shadow[p] = v;
      op(3'd1, p, 1'b0, 8'h00, r); chk("R5 via R0", r, v);
      op(3'd2, 8'd1, 1'b1, p + 8'd1, r); shadow[9] = p + 8'd1;
      op(3'd3, 8'h01, 1'b1, ~v, r); shadow[p+1] = ~v;
      op(3'd3, 8'h01, 1'b0, 8'h00, r); chk("R5 via R1", r, ~v);
    end
    op(3'd2, 8'd1, 1'b1, 8'h90, r); shadow[9] = 8'h90;
    op(3'd3, 8'h01, 1'b1, 8'hEE, r);
    op(3'd3, 8'h01, 1'b0, 8'h00, r); chk("R5 high ptr read", r, 8'h00);
    op(3'd1, 8'h10, 1'b0, 8'h00, r); chk("R5 high ptr no write", r, shadow[16]);
    op(3'd1, 8'hD0, 1'b1, 8'h00, r);

    // R6/R7 stack
    op(3'd4, 8'h00, 1'b0, 8'hC1, r); chk("R9 push rd zero", r, 8'h00);
    op(3'd4, 8'h00, 1'b0, 8'hC2, r);
    op(3'd4, 8'h00, 1'b0, 8'hC3, r);
    op(3'd1, 8'h81, 1'b0, 8'h00, r); chk("R6 SP after pushes", r, 8'h0A);
    op(3'd1, 8'h08, 1'b0, 8'h00, r); chk("R6 first push at 08", r, 8'hC1);
    op(3'd1, 8'h09, 1'b0, 8'h00, r); chk("R6 second push", r, 8'hC2);
    op(3'd1, 8'h0A, 1'b0, 8'h00, r); chk("R6 third push", r, 8'hC3);
    op(3'd5, 8'h00, 1'b0, 8'h00, r); chk("R7 pop 1", r, 8'hC3);
    op(3'd5, 8'h00, 1'b0, 8'h00, r); chk("R7 pop 2", r, 8'hC2);
    op(3'd5, 8'h00, 1'b0, 8'h00, r); chk("R7 pop 3", r, 8'hC1);
    op(3'd1, 8'h81, 1'b0, 8'h00, r); chk("R7 SP restored", r, 8'h07);

    // R9 idle modes
    op(3'd0, 8'h08, 1'b1, 8'h99, r); chk("R9 idle rd", r, 8'h00);
    op(3'd7, 8'h08, 1'b1, 8'h99, r); chk("R9 mode7 rd", r, 8'h00);
    op(3'd1, 8'h08, 1'b0, 8'h00, r); chk("R9 idle no write", r, 8'hC1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule